// File: doc/BRIEF.md
# Programmable Step Ramp Generator

The block drives a 12-bit converter code that walks from a programmed start value toward a programmed end value. Each move changes the code by a 4-bit step, upward or downward. Four ramp profiles are held in separate slots, and each slot has its own trigger bit. A shared 16-bit divider sets how many clock cycles pass between code updates. When the code reaches the end value, the ramp either parks there or restarts from the start value. A sticky completion flag records each arrival at the end value, and this flag can raise an interrupt.

Software sets up the block through a small word-wide register port. Slot words sit at addresses 0 to 3. The control word is at address 4: bits 15:0 hold the divider and bit 16 selects the trigger mode. The trigger bits are at address 5, one bit per slot. The completion flag is bit 0 at address 6, and the interrupt enable is bit 0 at address 7. Reads of every address are combinational from the address. The block never changes its code output on its own while it is idle.

Top module: `step_ramp_gen`

## Requirements
- R1: After reset the code output is 0. Busy and the interrupt are low. The trigger bits and the completion flag read as 0.
- R2: Each slot word is laid out as follows: start value in bits 11:0, step in bits 15:12, end value in bits 27:16, direction in bit 28 (0 up, 1 down) and repeat in bit 29. An upward ramp adds the step on each update, for example 0, 3, 6, 9.
- R3: A downward ramp subtracts the step on each update.
- R4: If a move would reach or pass the end value, the code is set exactly to the end value and the ramp counts as complete. In single mode without repeat, busy then drops.
- R5: With a step of 0 the code stays at the start value, busy stays high and the ramp never completes.
- R6: In repeat mode, the update after the end value is reached reloads the start value, and the ramp runs again.
- R7: The code takes the start value one cycle after the trigger write. After that it changes once every N cycles, where N is control bits 15:0 and a value of 0 counts as 1.
- R8: In single mode (control bit 16 = 0), writing 1 to a trigger bit requests that slot. Writing 0 has no effect. The bit clears itself in the cycle the slot starts.
- R9: In continual mode (control bit 16 = 1), trigger bits are plain levels and do not clear themselves. A ramp without repeat parks at the end value with busy high for as long as its bit stays set. Clearing the bit makes busy drop one cycle later, and the code keeps its last value.
- R10: When several slots are requested while the block is idle, the lowest-numbered slot starts first. The other slots stay pending and start once the block is idle again.
- R11: The completion flag is set on every arrival at the end value. Writing 1 to it clears it, but a set in the same cycle wins over the clear.
- R12: The interrupt output is high exactly when both the completion flag and the interrupt enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| code_o | output | 12 | Converter code |
| busy_o | output | 1 | A ramp is running or parked |
| irq_o | output | 1 | Completion interrupt |

## Verification
Two events can fall in the same cycle: the ramp arriving at its end value, which sets the completion flag, and a software write of 1 that clears the same flag. The bench runs a unit-step ramp with a divider of 1, so it knows the exact cycle of arrival. It times the clearing write to land on that edge. It then expects the flag and the interrupt to stay high, and it expects a second, isolated clear to take effect. Slot arbitration is checked the same way, by requesting two slots in one write and watching the order in which their start values appear.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  localparam int CODE_W = 12;
  localparam int STEP_W = 4;
  localparam int DATA_W = 32;

  // field order is the software layout of a slot word
  typedef struct packed {
    logic              rpt;
    logic              down;
    logic [CODE_W-1:0] end_pt;
    logic [STEP_W-1:0] step;
    logic [CODE_W-1:0] start_pt;
  } slot_cfg_t;

  localparam int CFG_W = $bits(slot_cfg_t);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} ramp_state_e;
endpackage

// File: rtl/ramp_regs.sv
module ramp_regs
  import ramp_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int DIV_W   = 16,
  parameter int ADDR_W  = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [N_SLOTS-1:0]          consume_i,
  input  logic                        complete_i,
  output slot_cfg_t [N_SLOTS-1:0]     cfg_o,
  output logic [DIV_W-1:0]            div_o,
  output logic                        cont_o,
  output logic [N_SLOTS-1:0]          trig_o,
  output logic                        trig_we_o,
  output logic                        done_o,
  output logic                        irq_en_o,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(N_SLOTS);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(N_SLOTS + 1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(N_SLOTS + 2);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(N_SLOTS + 3);

  logic [DIV_W-1:0]   div_q;
  logic               cont_q;
  logic [N_SLOTS-1:0] trig_q;
  logic               done_q;
  logic               ien_q;
  logic               unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:CFG_W];
  assign trig_we_o = we_i && (addr_i == A_TRIG);

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    slot_cfg_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && addr_i == ADDR_W'(s)) q <= slot_cfg_t'(wdata_i[CFG_W-1:0]);
    end
    assign cfg_o[s] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      cont_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (we_i && addr_i == A_CTRL) begin
        div_q  <= wdata_i[DIV_W-1:0];
        cont_q <= wdata_i[DIV_W];
      end
      if (we_i && addr_i == A_IEN) ien_q <= wdata_i[0];
    end
  end

  // single mode: write-one arms, start consumes; continual: plain level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else if (cont_q) begin
      if (trig_we_o) trig_q <= wdata_i[N_SLOTS-1:0];
    end else begin
      trig_q <= (trig_q & ~consume_i) | (trig_we_o ? wdata_i[N_SLOTS-1:0] : '0);
    end
  end

  // set beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else done_q <= (done_q & ~(we_i && addr_i == A_STAT && wdata_i[0])) | complete_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < N_SLOTS; s++)
      if (addr_i == ADDR_W'(s)) rdata_o = {{(DATA_W-CFG_W){1'b0}}, cfg_o[s]};
    if (addr_i == A_CTRL) rdata_o = {{(DATA_W-DIV_W-1){1'b0}}, cont_q, div_q};
    if (addr_i == A_TRIG) rdata_o = {{(DATA_W-N_SLOTS){1'b0}}, trig_q};
    if (addr_i == A_STAT) rdata_o = {{(DATA_W-1){1'b0}}, done_q};
    if (addr_i == A_IEN)  rdata_o = {{(DATA_W-1){1'b0}}, ien_q};
  end

  assign div_o    = div_q;
  assign cont_o   = cont_q;
  assign trig_o   = trig_q;
  assign done_o   = done_q;
  assign irq_en_o = ien_q;
endmodule

// File: rtl/ramp_arb.sv
module ramp_arb #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N-1:0] seen;

  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_first
      assign grant_o[i] = req_i[i];
      assign seen[i]    = req_i[i];
    end else begin : g_rest
      assign grant_o[i] = req_i[i] & ~seen[i-1];
      assign seen[i]    = seen[i-1] | req_i[i];
    end
  end

  assign any_o = seen[N-1];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/ramp_rate.sv
module ramp_rate #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last   = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = run_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ramp_core.sv
module ramp_core
  import ramp_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int IDX_W   = $clog2(N_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_any_i,
  input  logic [IDX_W-1:0]   sel_idx_i,
  input  slot_cfg_t          sel_cfg_i,
  input  logic               cont_i,
  input  logic [N_SLOTS-1:0] trig_i,
  input  logic               tick_i,
  output logic               start_o,
  output logic               complete_o,
  output logic               run_o,
  output logic               busy_o,
  output logic [CODE_W-1:0]  code_o,
  output slot_cfg_t          act_cfg_o
);
  ramp_state_e       state_q;
  slot_cfg_t         act_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CODE_W-1:0] code_q;
  logic              wrap_q;

  logic              stop, stepping, reach;
  logic [CODE_W:0]   step_x, up_sum, dn_lim;
  logic [CODE_W-1:0] nxt;

  assign step_x = {{(CODE_W+1-STEP_W){1'b0}}, act_q.step};
  assign up_sum = {1'b0, code_q} + step_x;
  assign dn_lim = {1'b0, act_q.end_pt} + step_x;
  assign reach  = act_q.down ? ({1'b0, code_q} <= dn_lim) : (up_sum >= {1'b0, act_q.end_pt});
  assign nxt    = act_q.down ? code_q - step_x[CODE_W-1:0] : up_sum[CODE_W-1:0];

  assign stop = (state_q != ST_IDLE) &&
                ((cont_i && !trig_i[idx_q]) || (state_q == ST_HOLD && !cont_i));
  assign start_o    = (state_q == ST_IDLE) && req_any_i;
  assign stepping   = (state_q == ST_RUN) && tick_i && !stop && (act_q.step != '0);
  assign complete_o = stepping && !wrap_q && reach;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      idx_q   <= '0;
      code_q  <= '0;
      wrap_q  <= 1'b0;
    end else if (start_o) begin
      state_q <= ST_RUN;
      act_q   <= sel_cfg_i;
      idx_q   <= sel_idx_i;
      code_q  <= sel_cfg_i.start_pt;
      wrap_q  <= 1'b0;
    end else if (stop) begin
      state_q <= ST_IDLE;
      wrap_q  <= 1'b0;
    end else if (stepping) begin
      if (wrap_q) begin
        code_q <= act_q.start_pt;
        wrap_q <= 1'b0;
      end else if (reach) begin
        code_q <= act_q.end_pt;
        if (act_q.rpt) wrap_q <= 1'b1;
        else state_q <= cont_i ? ST_HOLD : ST_IDLE;
      end else begin
        code_q <= nxt;
      end
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign busy_o    = (state_q != ST_IDLE);
  assign code_o    = code_q;
  assign act_cfg_o = act_q;
endmodule

// File: rtl/step_ramp_gen.sv
module step_ramp_gen
  import ramp_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int DIV_W   = 16,
  parameter int ADDR_W  = $clog2(N_SLOTS + 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [11:0]       code_o,
  output logic              busy_o,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(N_SLOTS);

  slot_cfg_t [N_SLOTS-1:0] cfg_w;
  slot_cfg_t               act_cfg_w;
  logic [DIV_W-1:0]        div_w;
  logic                    cont_w, trig_we_w, done_w, irq_en_w;
  logic [N_SLOTS-1:0]      trig_w, grant_w, consume_w;
  logic [IDX_W-1:0]        sel_idx_w;
  logic                    req_any_w, start_w, complete_w, run_w, tick_w;

  assign consume_w = (start_w && !cont_w) ? grant_w : '0;

  ramp_regs #(.N_SLOTS(N_SLOTS), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .consume_i(consume_w), .complete_i(complete_w),
    .cfg_o(cfg_w), .div_o(div_w), .cont_o(cont_w), .trig_o(trig_w),
    .trig_we_o(trig_we_w), .done_o(done_w), .irq_en_o(irq_en_w),
    .rdata_o(reg_rdata_o)
  );

  ramp_arb #(.N(N_SLOTS), .IDX_W(IDX_W)) u_arb (
    .req_i(trig_w), .grant_o(grant_w), .idx_o(sel_idx_w), .any_o(req_any_w)
  );

  ramp_rate #(.DIV_W(DIV_W)) u_rate (
    .clk_i, .rst_ni, .run_i(run_w), .div_i(div_w), .tick_o(tick_w)
  );

  ramp_core #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_core (
    .clk_i, .rst_ni,
    .req_any_i(req_any_w), .sel_idx_i(sel_idx_w), .sel_cfg_i(cfg_w[sel_idx_w]),
    .cont_i(cont_w), .trig_i(trig_w), .tick_i(tick_w),
    .start_o(start_w), .complete_o(complete_w), .run_o(run_w),
    .busy_o(busy_o), .code_o(code_o), .act_cfg_o(act_cfg_w)
  );

  assign irq_o = done_w & irq_en_w;
endmodule

// File: rtl/step_ramp_chk.sv
module step_ramp_chk #(
  parameter int N_SLOTS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic [11:0]        code_o,
  input logic               start_w,
  input logic               complete_w,
  input logic               run_w,
  input logic               cont_w,
  input logic               trig_we_w,
  input logic               done_w,
  input logic [N_SLOTS-1:0] trig_w,
  input logic [N_SLOTS-1:0] grant_w,
  input logic [11:0]        act_end,
  input logic [3:0]         act_step
);
  p_end_on_complete_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_w |=> code_o == $past(act_end));

  p_zero_step_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && act_step == 4'd0) |=> $stable(code_o));

  p_trig_self_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w && !cont_w && !trig_we_w) |=> ((trig_w & $past(grant_w)) == '0));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_w) |=> $stable(code_o));

  p_lowest_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_w != '0) |-> ($onehot(grant_w) && (grant_w & trig_w) != '0 &&
                        ((grant_w - 1'b1) & trig_w) == '0));

  p_done_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_w |=> done_w);
endmodule

bind step_ramp_gen step_ramp_chk #(.N_SLOTS(N_SLOTS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .code_o(code_o),
  .start_w(start_w), .complete_w(complete_w), .run_w(run_w), .cont_w(cont_w),
  .trig_we_w(trig_we_w), .done_w(done_w), .trig_w(trig_w), .grant_w(grant_w),
  .act_end(act_cfg_w.end_pt), .act_step(act_cfg_w.step)
);

// File: tb/tb_step_ramp_gen.sv
module tb_step_ramp_gen;
  localparam int CLK_PERIOD = 10;
  localparam int A_CTRL = 4, A_TRIG = 5, A_STAT = 6, A_IEN = 7;
  localparam int CONT = 1 << 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [11:0] code_o;
  logic        busy_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  step_ramp_gen dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr_i = 3'(a); #1;
    d = reg_rdata_o;
  endtask

  function automatic int mk_cfg(int st, int stp, int en, bit dn, bit rp);
    return (int'(rp) << 29) | (int'(dn) << 28) | ((en & 12'hfff) << 16) | ((stp & 4'hf) << 12) | (st & 12'hfff);
  endfunction

  function automatic int model_next(int cur, int stp, int en, bit dn, output bit hit);
    hit = 1'b0;
    if (!dn) begin
      if (cur + stp >= en) begin hit = 1'b1; return en; end
      return cur + stp;
    end
    if (cur <= en + stp) begin hit = 1'b1; return en; end
    return cur - stp;
  endfunction

  // single-mode, non-repeat ramp checked update by update
  task automatic run_ramp(input int slot, input int st, input int stp, input int en,
                          input bit dn, input int d, input string tag);
    int cur, guard, v;
    bit hit;
    wr(slot, mk_cfg(st, stp, en, dn, 1'b0));
    wr(A_CTRL, d);
    wr(A_STAT, 1);
    wr(A_TRIG, 1 << slot);
    @(posedge clk_i); #1;
    chk(code_o == 12'(st), "R7", "start value one cycle after trigger", code_o, st);
    cur = st; hit = 1'b0; guard = 0;
    while (!hit && guard < 300) begin
      if (d > 1) begin
        repeat (d - 1) @(posedge clk_i);
        #1;
        chk(code_o == 12'(cur), "R7", "hold between updates", code_o, cur);
      end
      @(posedge clk_i); #1;
      cur = model_next(cur, stp, en, dn, hit);
      chk(code_o == 12'(cur), tag, "ramp value", code_o, cur);
      guard++;
    end
    chk(busy_o == 1'b0, "R4", "busy low after completion", busy_o, 0);
    rd(A_STAT, v);
    chk(v == 1, "R11", "flag set on completion", v, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog R7: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v, dummy, seq[7];
    dummy = $urandom(32'h5eed_0042);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1
    chk(code_o == 0, "R1", "code after reset", code_o, 0);
    chk(busy_o == 0, "R1", "busy after reset", busy_o, 0);
    chk(irq_o == 0, "R1", "irq after reset", irq_o, 0);
    rd(A_TRIG, v); chk(v == 0, "R1", "trigger bits after reset", v, 0);
    rd(A_STAT, v); chk(v == 0, "R1", "flag after reset", v, 0);

    // directed ramps
    run_ramp(0, 0, 3, 9, 1'b0, 1, "R2");
    run_ramp(1, 0, 4, 10, 1'b0, 2, "R4");
    run_ramp(2, 20, 7, 5, 1'b1, 3, "R3");
    run_ramp(3, 3, 5, 0, 1'b1, 1, "R4");
    run_ramp(0, 5, 2, 11, 1'b0, 0, "R7");

    // R8: trigger cleared once slot starts; writing 0 leaves a pending bit
    wr(1, mk_cfg(100, 1, 102, 1'b0, 1'b0));
    wr(2, mk_cfg(200, 1, 201, 1'b0, 1'b0));
    wr(A_CTRL, 1);
    wr(A_TRIG, 32'b0110);
    rd(A_TRIG, v); chk(v == 32'b0110, "R8", "armed bits before start", v, 6);
    @(posedge clk_i); #1;
    chk(code_o == 100, "R10", "lowest slot first", code_o, 100);
    rd(A_TRIG, v); chk(v == 32'b0100, "R8", "started bit self-cleared", v, 4);
    @(posedge clk_i); #1; chk(code_o == 101, "R10", "slot1 ramp", code_o, 101);
    @(posedge clk_i); #1; chk(code_o == 102, "R10", "slot1 end", code_o, 102);
    chk(busy_o == 0, "R10", "idle between slots", busy_o, 0);
    @(posedge clk_i); #1; chk(code_o == 200, "R10", "pending slot starts next", code_o, 200);
    rd(A_TRIG, v); chk(v == 0, "R8", "all requests consumed", v, 0);
    @(posedge clk_i); #1; chk(code_o == 201, "R10", "slot2 end", code_o, 201);

    // R5: zero step holds start, then stopped through continual mode
    wr(A_STAT, 1);
    wr(0, mk_cfg(55, 0, 60, 1'b0, 1'b0));
    wr(A_CTRL, 2);
    wr(A_TRIG, 1);
    repeat (10) @(posedge clk_i);
    #1;
    chk(code_o == 55, "R5", "zero step holds start", code_o, 55);
    chk(busy_o == 1, "R5", "zero step stays busy", busy_o, 1);
    rd(A_STAT, v); chk(v == 0, "R5", "zero step never completes", v, 0);
    wr(A_CTRL, CONT | 2);
    @(posedge clk_i); #1;
    chk(busy_o == 0, "R9", "cleared level stops ramp", busy_o, 0);
    chk(code_o == 55, "R9", "code held after stop", code_o, 55);

    // R6: repeat mode
    wr(A_CTRL, 1);
    wr(A_STAT, 1);
    wr(3, mk_cfg(10, 3, 16, 1'b0, 1'b1));
    wr(A_TRIG, 8);
    seq = '{10, 13, 16, 10, 13, 16, 10};
    for (int i = 0; i < 7; i++) begin
      @(posedge clk_i); #1;
      chk(code_o == 12'(seq[i]), "R6", "repeat sequence", code_o, seq[i]);
      if (i == 1) begin rd(A_STAT, v); chk(v == 0, "R11", "flag before end", v, 0); end
      if (i == 2) begin rd(A_STAT, v); chk(v == 1, "R11", "flag at end", v, 1); end
    end
    chk(busy_o == 1, "R6", "repeat keeps running", busy_o, 1);
    wr(A_CTRL, CONT | 1);
    @(posedge clk_i); #1;
    chk(busy_o == 0, "R9", "repeat ramp stopped", busy_o, 0);

    // R9: continual level, parks at end
    wr(A_STAT, 1);
    wr(2, mk_cfg(30, 5, 20, 1'b1, 1'b0));
    wr(A_CTRL, CONT | 2);
    wr(A_TRIG, 4);
    @(posedge clk_i); #1; chk(code_o == 30, "R9", "continual start", code_o, 30);
    repeat (2) @(posedge clk_i); #1; chk(code_o == 25, "R3", "continual down step", code_o, 25);
    repeat (2) @(posedge clk_i); #1; chk(code_o == 20, "R9", "continual end", code_o, 20);
    repeat (5) @(posedge clk_i); #1;
    chk(code_o == 20, "R9", "parked at end", code_o, 20);
    chk(busy_o == 1, "R9", "parked stays busy", busy_o, 1);
    rd(A_TRIG, v); chk(v == 4, "R9", "level not self-cleared", v, 4);
    wr(A_TRIG, 0);
    @(posedge clk_i); #1;
    chk(busy_o == 0, "R9", "busy drops after level clears", busy_o, 0);
    chk(code_o == 20, "R9", "code kept after stop", code_o, 20);

    // R11/R12: set and clear in the same cycle
    wr(A_CTRL, 1);
    wr(A_STAT, 1);
    wr(A_IEN, 1);
    wr(0, mk_cfg(0, 1, 3, 1'b0, 1'b0));
    wr(A_TRIG, 1);
    repeat (3) @(posedge clk_i);
    wr(A_STAT, 1);
    chk(code_o == 3, "R11", "end reached on collision edge", code_o, 3);
    rd(A_STAT, v); chk(v == 1, "R11", "set wins over clear", v, 1);
    chk(irq_o == 1, "R12", "irq with flag and enable", irq_o, 1);
    wr(A_IEN, 0);
    chk(irq_o == 0, "R12", "irq masked by enable", irq_o, 0);
    wr(A_IEN, 1);
    wr(A_STAT, 1);
    rd(A_STAT, v); chk(v == 0, "R11", "isolated clear", v, 0);
    chk(irq_o == 0, "R12", "irq low after clear", irq_o, 0);

    // constrained random single-mode ramps
    for (int k = 0; k < 12; k++) begin
      int s, st, en, stp, d;
      bit dn;
      s   = int'($urandom % 4);
      st  = int'($urandom % 64);
      en  = int'($urandom % 64);
      stp = 1 + int'($urandom % 15);
      dn  = st > en;
      d   = 1 + int'($urandom % 3);
      run_ramp(s, st, stp, en, dn, d, dn ? "R3" : "R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule